// File: doc/BRIEF.md
# Programmable Panel Raster Timing Generator

This block produces the raster timing of a TFT panel: horizontal sync, vertical sync, data enable, the current active pixel and active line index, and a one-clock end-of-frame marker. Software loads a horizontal timing word, a vertical timing word and a control word through a simple write port. Each line and each frame runs through four segments in this order: active, front porch, sync, back porch. The block copies the timing words into a shadow set while it is disabled and at each frame boundary. A write in the middle of a frame therefore never tears the current frame.

The control word enables the raster and powers the panel. It inverts each of the three timing outputs on its own, and it tells a downstream pixel launcher which pixel clock edge to use. A frame base address is double buffered. A written address waits until the next frame boundary, where it becomes the active address and sets an update status bit. The status bit drives an interrupt through an enable bit and is cleared by writing a one to a clear register.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset every output is low: hsync_o, vsync_o, de_o, eof_o, pix_x_o, line_y_o, launch_fall_o, panel_pwr_o, base_addr_o, upd_raw_o and irq_o.
- R2: The horizontal word at address 0 sets the line. Bits [5:0] hold active width/16 − 1. Bits [15:8] hold sync width − 1, bits [23:16] front porch − 1 and bits [31:24] back porch − 1. A line is active, front porch, sync, back porch in that order. de_o is high on active pixels, hsync_o is high during the sync segment, and pix_x_o counts 0 upward on active pixels and is 0 elsewhere.
- R3: The vertical word at address 1 sets the frame. Bits [9:0] hold active lines − 1 and bits [15:10] hold sync lines − 1. Bits [23:16] hold the front porch lines and bits [31:24] the back porch lines, both with no offset, and zero is allowed. vsync_o is high for whole sync lines, and line_y_o is the line index on active lines and 0 elsewhere.
- R4: eof_o is high for exactly one clock, the last pixel clock of the frame. That clock is the final pixel of the last back porch line, or of the last sync line when the back porch is zero.
- R5: The control word at address 2 has these bits: bit0 enable, bit1 panel power, bit2 invert hsync, bit3 invert vsync, bit4 invert data enable, bit5 falling-edge launch. Each inversion bit flips only its own output and applies at once.
- R6: While the enable bit is 0, the counters are 0 and eof_o is 0. hsync_o, vsync_o and de_o each sit at their inactive level, which equals that output's inversion bit. The first clock after the enabling write is pixel 0 of line 0.
- R7: Timing words written during a frame do not affect that frame. They take effect from the next frame.
- R8: panel_pwr_o is high only while both the enable bit and the power bit are set. Clearing the enable bit drops it in the same clock as the raster stops.
- R9: launch_fall_o follows control bit5.
- R10: A write to address 3 loads a pending base address with bits [1:0] forced to 0. base_addr_o takes that value only at the end of the frame that is running, and does not change otherwise.
- R11: Applying a pending base address sets upd_raw_o. irq_o is upd_raw_o AND bit0 of the enable register at address 4. Writing 1 in bit0 of address 5 clears upd_raw_o. A frame end with no pending address sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control |
| vsync_o | output | 1 | Vertical sync, polarity per control |
| de_o | output | 1 | Data enable, polarity per control |
| pix_x_o | output | 11 | Active pixel index |
| line_y_o | output | 11 | Active line index |
| eof_o | output | 1 | One-clock end-of-frame pulse |
| launch_fall_o | output | 1 | Pixel data launch on falling edge |
| panel_pwr_o | output | 1 | Panel power enable |
| base_addr_o | output | 32 | Active frame base address |
| upd_raw_o | output | 1 | Base update status |
| irq_o | output | 1 | Masked base update interrupt |

## Verification
The hardest case to reach is a timing change and a base address write that both land in the middle of a frame. Correct behaviour here shows in two places: the frame that is running must finish on its old shape, and the address must appear only at the frame boundary. The stimulus enables the raster and waits well into the second frame. It then writes a new base address and both timing words with a different shape, including zero vertical porches. The expected queue holds two frames of the first shape followed by one frame of the second, and the base and status bits are sampled just before and just after the boundary. A second pass re-enables with all three inversions set. It also checks the inactive levels while the raster is disabled.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    // timing word field widths
    localparam int PPL_W  = 6;
    localparam int HSW_W  = 8;
    localparam int HFP_W  = 8;
    localparam int HBP_W  = 8;
    localparam int LPP_W  = 10;
    localparam int VSW_W  = 6;
    localparam int VFP_W  = 8;
    localparam int VBP_W  = 8;

    // field positions inside the timing words
    localparam int HSW_LSB = 8;
    localparam int HFP_LSB = 16;
    localparam int HBP_LSB = 24;
    localparam int VSW_LSB = LPP_W;
    localparam int VFP_LSB = 16;
    localparam int VBP_LSB = 24;

    localparam int WORD_W  = 32;
    localparam int REG_AW  = 3;
    localparam int GRAIN   = 16;

    // counter widths large enough for the longest programmable line / frame
    localparam int HC_W = $clog2((2**PPL_W) * GRAIN + 2**HSW_W + 2**HFP_W + 2**HBP_W + 1);
    localparam int VC_W = $clog2(2**LPP_W + 2**VSW_W + 2**VFP_W + 2**VBP_W + 1);

    typedef enum logic [REG_AW-1:0] {
        A_HTIM = 3'd0,
        A_VTIM = 3'd1,
        A_CTRL = 3'd2,
        A_BASE = 3'd3,
        A_IEN  = 3'd4,
        A_ICLR = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic fall;
        logic inv_de;
        logic inv_v;
        logic inv_h;
        logic pwr;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [HC_W-1:0] h_act;
        logic [HC_W-1:0] h_fp;
        logic [HC_W-1:0] h_sw;
        logic [HC_W-1:0] h_bp;
        logic [VC_W-1:0] v_act;
        logic [VC_W-1:0] v_fp;
        logic [VC_W-1:0] v_sw;
        logic [VC_W-1:0] v_bp;
    } timing_t;

    // Turn the encoded words into real segment lengths.
    function automatic timing_t decode_timing(input logic [WORD_W-1:0] ht,
                                              input logic [WORD_W-1:0] vt);
        timing_t t;
        t.h_act = HC_W'((32'(ht[PPL_W-1:0]) + 32'd1) * 32'(GRAIN));
        t.h_sw  = HC_W'(32'(ht[HSW_LSB +: HSW_W]) + 32'd1);
        t.h_fp  = HC_W'(32'(ht[HFP_LSB +: HFP_W]) + 32'd1);
        t.h_bp  = HC_W'(32'(ht[HBP_LSB +: HBP_W]) + 32'd1);
        t.v_act = VC_W'(32'(vt[LPP_W-1:0]) + 32'd1);
        t.v_sw  = VC_W'(32'(vt[VSW_LSB +: VSW_W]) + 32'd1);
        t.v_fp  = VC_W'(vt[VFP_LSB +: VFP_W]);
        t.v_bp  = VC_W'(vt[VBP_LSB +: VBP_W]);
        return t;
    endfunction

endpackage

// File: rtl/lcd_axis.sv
// One raster axis: active, front porch, sync, back porch, then wrap.
module lcd_axis #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_fp,
    input  logic [CW-1:0] len_sw,
    input  logic [CW-1:0] len_bp,
    output logic [CW-1:0] cnt_o,
    output logic          act_o,
    output logic          sync_o,
    output logic          last_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] fp_end, sw_end, total_m1;

    always_comb begin
        fp_end   = len_act + len_fp;
        sw_end   = fp_end + len_sw;
        total_m1 = sw_end + len_bp - CW'(1);
        act_o    = cnt_q < len_act;
        sync_o   = (cnt_q >= fp_end) && (cnt_q < sw_end);
        last_o   = cnt_q == total_m1;
        cnt_d    = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = last_o ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= total_m1));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && last_o) |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_cfg_regs.sv
// Register file: timing words, control, buffered base address, update status.
module lcd_cfg_regs
    import lcd_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_wrap,
    output logic [WORD_W-1:0] htim_o,
    output logic [WORD_W-1:0] vtim_o,
    output ctrl_t             ctrl_o,
    output logic [WORD_W-1:0] base_o,
    output logic              raw_o,
    output logic              irq_o,
    output logic              pwr_o
);

    typedef struct packed {
        logic [WORD_W-1:0] htim;
        logic [WORD_W-1:0] vtim;
        ctrl_t             ctrl;
        logic [WORD_W-1:0] pend;
        logic              pend_v;
        logic [WORD_W-1:0] base;
        logic              raw;
        logic              ien;
        logic              pwr;
    } st_t;

    st_t  s_d, s_q;
    logic apply;
    logic base_wr;

    always_comb begin
        s_d     = s_q;
        apply   = frame_wrap && s_q.pend_v;
        base_wr = wr_en && (wr_addr == A_BASE);
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_HTIM: s_d.htim = wr_data;
                A_VTIM: s_d.vtim = wr_data;
                A_CTRL: s_d.ctrl = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                A_BASE: begin
                    s_d.pend   = {wr_data[WORD_W-1:2], 2'b00};
                    s_d.pend_v = 1'b1;
                end
                A_IEN:  s_d.ien = wr_data[0];
                A_ICLR: if (wr_data[0]) s_d.raw = 1'b0;
                default: ;
            endcase
        end
        // a frame boundary applies the older pending address; setting wins over clearing
        if (apply) begin
            s_d.base = s_q.pend;
            s_d.raw  = 1'b1;
            if (!base_wr) begin
                s_d.pend_v = 1'b0;
            end
        end
        s_d.pwr = s_d.ctrl.pwr & s_d.ctrl.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign htim_o = s_q.htim;
    assign vtim_o = s_q.vtim;
    assign ctrl_o = s_q.ctrl;
    assign base_o = s_q.base;
    assign raw_o  = s_q.raw;
    assign irq_o  = s_q.raw & s_q.ien;
    assign pwr_o  = s_q.pwr;

    // R10
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(s_q.base));

    // R10
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.base[1:0] == 2'b00);

    // R11
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> s_q.raw);

    // R8
    pwr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pwr |-> s_q.ctrl.en);

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcd_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [HC_W-1:0]   pix_x_o,
    output logic [VC_W-1:0]   line_y_o,
    output logic              eof_o,
    output logic              launch_fall_o,
    output logic              panel_pwr_o,
    output logic [WORD_W-1:0] base_addr_o,
    output logic              upd_raw_o,
    output logic              irq_o
);

    typedef struct packed {
        timing_t tm;
    } st_t;

    st_t s_d, s_q;

    logic [WORD_W-1:0] htim, vtim;
    ctrl_t             ctrl;
    logic              frame_wrap;
    logic [HC_W-1:0]   h_cnt;
    logic [VC_W-1:0]   v_cnt;
    logic              h_act, h_sync, h_last;
    logic              v_act, v_sync, v_last;
    logic              de_raw;

    lcd_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .htim_o     (htim),
        .vtim_o     (vtim),
        .ctrl_o     (ctrl),
        .base_o     (base_addr_o),
        .raw_o      (upd_raw_o),
        .irq_o      (irq_o),
        .pwr_o      (panel_pwr_o)
    );

    lcd_axis #(.CW(HC_W)) u_h (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.en),
        .step    (1'b1),
        .len_act (s_q.tm.h_act),
        .len_fp  (s_q.tm.h_fp),
        .len_sw  (s_q.tm.h_sw),
        .len_bp  (s_q.tm.h_bp),
        .cnt_o   (h_cnt),
        .act_o   (h_act),
        .sync_o  (h_sync),
        .last_o  (h_last)
    );

    lcd_axis #(.CW(VC_W)) u_v (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.en),
        .step    (h_last),
        .len_act (s_q.tm.v_act),
        .len_fp  (s_q.tm.v_fp),
        .len_sw  (s_q.tm.v_sw),
        .len_bp  (s_q.tm.v_bp),
        .cnt_o   (v_cnt),
        .act_o   (v_act),
        .sync_o  (v_sync),
        .last_o  (v_last)
    );

    // shadow timing: tracks the words while idle, reloads only at frame end
    always_comb begin
        s_d        = s_q;
        frame_wrap = ctrl.en && h_last && v_last;
        if (!ctrl.en || frame_wrap) begin
            s_d.tm = decode_timing(htim, vtim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        de_raw        = ctrl.en && h_act && v_act;
        de_o          = ctrl.inv_de ^ de_raw;
        hsync_o       = ctrl.inv_h ^ (ctrl.en && h_sync);
        vsync_o       = ctrl.inv_v ^ (ctrl.en && v_sync);
        pix_x_o       = de_raw ? h_cnt : '0;
        line_y_o      = (ctrl.en && v_act) ? v_cnt : '0;
        eof_o         = frame_wrap;
        launch_fall_o = ctrl.fall;
    end

    // R4
    eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.en) |=> (h_cnt == '0 && v_cnt == '0));

    // R3
    line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && !h_last) |=> $stable(v_cnt));

    // R7
    shadow_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && !(h_last && v_last)) |=> $stable(s_q.tm));

endmodule

// File: tb/sim_lcd_raster_gen.sv
module sim_lcd_raster_gen;
    import lcd_raster_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [REG_AW-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              hsync_o, vsync_o, de_o, eof_o;
    logic [HC_W-1:0]   pix_x_o;
    logic [VC_W-1:0]   line_y_o;
    logic              launch_fall_o, panel_pwr_o, upd_raw_o, irq_o;
    logic [WORD_W-1:0] base_addr_o;

    typedef struct packed {
        logic        hs;
        logic        vs;
        logic        de;
        logic        eof;
        logic [15:0] px;
        logic [15:0] ly;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    failures = 0;
    string tag = "R2";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    lcd_raster_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .hsync_o       (hsync_o),
        .vsync_o       (vsync_o),
        .de_o          (de_o),
        .pix_x_o       (pix_x_o),
        .line_y_o      (line_y_o),
        .eof_o         (eof_o),
        .launch_fall_o (launch_fall_o),
        .panel_pwr_o   (panel_pwr_o),
        .base_addr_o   (base_addr_o),
        .upd_raw_o     (upd_raw_o),
        .irq_o         (irq_o)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, expv);
        end
    endtask

    // driver side: expected per-clock outputs of one whole frame
    function automatic void push_frame(input int w, input int hfp, input int hsw, input int hbp,
                                       input int l, input int vfp, input int vsw, input int vbp,
                                       input bit ih, input bit iv, input bit id);
        int ht = w + hfp + hsw + hbp;
        int vt = l + vfp + vsw + vbp;
        for (int v = 0; v < vt; v++) begin
            for (int h = 0; h < ht; h++) begin
                exp_t e;
                bit   d;
                d     = (h < w) && (v < l);
                e.de  = d ^ id;
                e.hs  = ((h >= w + hfp) && (h < w + hfp + hsw)) ^ ih;
                e.vs  = ((v >= l + vfp) && (v < l + vfp + vsw)) ^ iv;
                e.eof = (v == vt - 1) && (h == ht - 1);
                e.px  = d ? 16'(h) : 16'd0;
                e.ly  = (v < l) ? 16'(v) : 16'd0;
                exp_q.push_back(e);
            end
        end
    endfunction

    // monitor side: one expected item per clock, sampled 2 ns after the edge
    always begin
        exp_t e;
        exp_t g;
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            g = {hsync_o, vsync_o, de_o, eof_o, 16'(pix_x_o), 16'(line_y_o)};
            check({tag, " raster"}, 64'(g), 64'(e));
        end
    end

    task automatic wr_begin(input logic [REG_AW-1:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [REG_AW-1:0] a, input logic [WORD_W-1:0] d);
        wr_begin(a, d);
        wr_end();
    endtask

    function automatic logic [63:0] idle_vec();
        return 64'({hsync_o, vsync_o, de_o, eof_o, 16'(pix_x_o), 16'(line_y_o)});
    endfunction

    // config A: 16 px, hfp 1, hsw 2, hbp 1; 3 lines, vfp 1, vsw 1, vbp 1
    localparam logic [31:0] HTIM_A = {8'd0, 8'd0, 8'd1, 2'b00, 6'd0};
    localparam logic [31:0] VTIM_A = {8'd1, 8'd1, 6'd0, 10'd2};
    // config B: 32 px, hfp 2, hsw 1, hbp 3; 2 lines, vfp 0, vsw 2, vbp 0
    localparam logic [31:0] HTIM_B = {8'd2, 8'd1, 8'd0, 2'b00, 6'd1};
    localparam logic [31:0] VTIM_B = {8'd0, 8'd0, 6'd1, 10'd1};

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 in reset", {idle_vec()[35:0], launch_fall_o, panel_pwr_o, upd_raw_o, irq_o, 24'd0}, 64'd0);
        check("R1 base in reset", 64'(base_addr_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {idle_vec()[35:0], launch_fall_o, panel_pwr_o, upd_raw_o, irq_o, 24'd0}, 64'd0);

        wr_reg(A_HTIM, HTIM_A);
        wr_reg(A_VTIM, VTIM_A);
        check("R6 idle before enable", idle_vec(), 64'd0);

        // two frames of A, then the frame after the mid-frame rewrite uses B (R7)
        wr_begin(A_CTRL, 32'h3);
        tag = "R2 R3 R4 R7";
        push_frame(16, 1, 2, 1, 3, 1, 1, 1, 1'b0, 1'b0, 1'b0);
        push_frame(16, 1, 2, 1, 3, 1, 1, 1, 1'b0, 1'b0, 1'b0);
        push_frame(32, 2, 1, 3, 2, 0, 2, 0, 1'b0, 1'b0, 1'b0);
        wr_end();
        check("R8 power on", 64'(panel_pwr_o), 64'd1);
        check("R9 rising launch", 64'(launch_fall_o), 64'd0);

        repeat (130) @(negedge clk);
        wr_reg(A_BASE, 32'h1000_0003);
        check("R10 base held mid-frame", 64'(base_addr_o), 64'd0);
        check("R11 no status before apply", 64'(upd_raw_o), 64'd0);
        wr_reg(A_HTIM, HTIM_B);
        wr_reg(A_VTIM, VTIM_B);

        repeat (110) @(negedge clk);
        check("R10 base applied aligned", 64'(base_addr_o), 64'h1000_0000);
        check("R11 status set", 64'(upd_raw_o), 64'd1);
        check("R11 irq masked", 64'(irq_o), 64'd0);
        wr_reg(A_IEN, 32'h1);
        check("R11 irq enabled", 64'(irq_o), 64'd1);
        wr_reg(A_ICLR, 32'h1);
        check("R11 cleared", 64'({upd_raw_o, irq_o}), 64'd0);

        while (exp_q.size() > 0) @(negedge clk);

        // disable with power bit left set
        wr_reg(A_CTRL, 32'h2);
        check("R6 stopped", idle_vec(), 64'd0);
        check("R8 power follows enable", 64'(panel_pwr_o), 64'd0);
        repeat (5) @(negedge clk);
        check("R6 held idle", idle_vec(), 64'd0);
        check("R10 base kept", 64'(base_addr_o), 64'h1000_0000);

        // re-enable with all inversions and falling launch
        wr_begin(A_CTRL, 32'h3F);
        tag = "R5 R6";
        push_frame(32, 2, 1, 3, 2, 0, 2, 0, 1'b1, 1'b1, 1'b1);
        wr_end();
        check("R9 falling launch", 64'(launch_fall_o), 64'd1);
        check("R8 power on again", 64'(panel_pwr_o), 64'd1);
        while (exp_q.size() > 0) @(negedge clk);

        wr_reg(A_CTRL, 32'h1C);
        check("R5 inactive inverted levels", idle_vec(), {28'd0, 4'b1110, 32'd0});
        check("R9 launch cleared", 64'(launch_fall_o), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule